// File: doc/BRIEF.md
# Page-Mode Parallel Flash Read Controller

This block sits on the host side of an asynchronous, word-wide NOR flash that supports page-mode reads. A client presents a 23-bit word address on a valid/ready request port and receives the 16-bit word on a one-cycle response strobe. The controller drives the chip-select, output-enable and write-enable strobes and the address bus. It waits a counted number of clock cycles before it samples the data bus. The wait counts are derived at elaboration from the clock period and the device access times.

A page is eight words. Address bits 22..3 form the page number and bits 2..0 pick the word inside it. A read that starts a page pays the full random-access wait, which is the longer of the address access time and the output-enable access time. The controller then keeps chip-select and output-enable low and remembers the open page. A later read whose page number matches is served after the short in-page wait only. A read to a different page, or any read after the strobes have been released, pays the full wait again. If no request arrives for a configurable number of cycles, the strobes are released and the page is closed.

The state machine has four states. CLOSED releases the strobes, holds no valid page and is ready. RAND is the full-length wait. PAGE is the short wait. OPEN holds the strobes low with a valid page tag and is ready. The transitions are:
- CLOSED→RAND on an accepted request.
- RAND→OPEN and PAGE→OPEN on the last wait cycle, which captures the data.
- OPEN→PAGE on an accepted request whose page matches.
- OPEN→RAND on an accepted request whose page differs.
- OPEN→CLOSED when the idle count expires with no request.

Top module: `pflash_rd_ctrl`

## Requirements
- R1: While reset is asserted, `fl_ce_n`, `fl_oe_n` and `fl_we_n` are 1, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A request is taken in a cycle where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the next cycle until the response cycle, and it is 1 again in the response cycle.
- R3: A request taken with strobes released drives `fl_ce_n` and `fl_oe_n` low and waits RAND_CYC = ceil(max(T_ACC_NS, T_OE_NS) / CLK_NS) cycles. With default parameters this is 6. `rsp_valid` is seen RAND_CYC+1 cycles after the request cycle.
- R4: A request taken in OPEN whose address bits 22..3 equal those of the last completed read waits PAGE_CYC = ceil(T_PAGE_NS / CLK_NS) cycles, which is 2 by default. The response is seen PAGE_CYC+1 cycles after the request cycle.
- R5: A request taken in OPEN whose bits 22..3 differ waits the full RAND_CYC. `fl_ce_n` stays low through the change.
- R6: `rsp_data` equals the `fl_dq` value sampled on the last wait cycle. `rsp_valid` is high for exactly one cycle per request.
- R7: `fl_we_n` is 1 at all times.
- R8: After IDLE_CYC consecutive OPEN cycles without a request, `fl_ce_n` and `fl_oe_n` return to 1 and the page is closed. IDLE_CYC is 16 by default. The next read waits the full RAND_CYC.
- R9: A request arriving in the cycle the idle count would expire wins: it is served as an in-page read when its page matches.
- R10: `fl_addr` equals the accepted request address and stays constant throughout every wait.
- R11: `fl_oe_n` always equals `fl_ce_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_addr | input | 23 | Word address of the request |
| rsp_valid | output | 1 | One-cycle strobe marking `rsp_data` valid |
| rsp_data | output | 16 | Word read from the flash |
| fl_ce_n | output | 1 | Flash chip select, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_we_n | output | 1 | Flash write enable, held high |
| fl_addr | output | 23 | Flash word address |
| fl_dq | input | 16 | Flash data bus |

## Verification
In OPEN, a new request and the expiry of the idle count can fall in the same cycle. The bench provokes this by holding off for exactly IDLE_CYC-1 cycles after a response and then issuing a same-page request. It judges the result by the request being served with the short latency while chip-select never rises. The neighbouring gap of IDLE_CYC cycles must instead show released strobes and a full-length wait. The response strobe and the acceptance of the next request also share a cycle. Back-to-back reads exercise this against a cycle-accurate reference model and a flash responder that returns a poison word whenever its access times are not met.

// File: rtl/pflash_pkg.sv
package pflash_pkg;

    typedef enum logic [1:0] {
        ST_CLOSED = 2'd0,
        ST_RAND   = 2'd1,
        ST_PAGE   = 2'd2,
        ST_OPEN   = 2'd3
    } rd_state_t;

    // Whole clock cycles covering a time in ns, at least one.
    function automatic int ns_to_cycles(input int t_ns, input int period_ns);
        int c;
        c = (t_ns + period_ns - 1) / period_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

endpackage

// File: rtl/pflash_wait_timer.sv
module pflash_wait_timer #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_cycles,
    output logic         done
);
    logic [W-1:0] cnt_q;

    // Loaded with N-1 on entry to a wait, so done rises in the Nth cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_cycles - W'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/pflash_idle_timer.sv
module pflash_idle_timer #(
    parameter int LIMIT = 16,
    parameter int W     = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    generate
        if (LIMIT == 0) begin : g_never
            assign expire = 1'b0;
        end else begin : g_count
            logic [W-1:0] cnt_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (!run) begin
                    cnt_q <= '0;
                end else if (cnt_q != W'(LIMIT - 1)) begin
                    cnt_q <= cnt_q + W'(1);
                end
            end

            assign expire = run && (cnt_q == W'(LIMIT - 1));
        end
    endgenerate
endmodule

// File: rtl/pflash_page_tag.sv
module pflash_page_tag #(
    parameter int TAG_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set,
    input  logic             clear,
    input  logic [TAG_W-1:0] set_tag,
    input  logic [TAG_W-1:0] probe_tag,
    output logic             hit
);
    logic [TAG_W-1:0] tag_q;
    logic             valid_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tag_q   <= '0;
            valid_q <= 1'b0;
        end else if (clear) begin
            valid_q <= 1'b0;
        end else if (set) begin
            tag_q   <= set_tag;
            valid_q <= 1'b1;
        end
    end

    assign hit = valid_q && (tag_q == probe_tag);
endmodule

// File: rtl/pflash_rd_ctrl.sv
module pflash_rd_ctrl #(
    parameter int ADDR_W    = 23,
    parameter int DATA_W    = 16,
    parameter int PAGE_BITS = 3,
    parameter int CLK_NS    = 10,
    parameter int T_ACC_NS  = 55,
    parameter int T_PAGE_NS = 20,
    parameter int T_OE_NS   = 25,
    parameter int IDLE_CYC  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              fl_ce_n,
    output logic              fl_oe_n,
    output logic              fl_we_n,
    output logic [ADDR_W-1:0] fl_addr,
    input  logic [DATA_W-1:0] fl_dq
);
    import pflash_pkg::*;

    localparam int T_FULL_NS = (T_ACC_NS > T_OE_NS) ? T_ACC_NS : T_OE_NS;
    localparam int RAND_CYC  = ns_to_cycles(T_FULL_NS, CLK_NS);
    localparam int PAGE_CYC  = ns_to_cycles(T_PAGE_NS, CLK_NS);
    localparam int WAIT_W    = $clog2(RAND_CYC + 1);
    localparam int IDLE_W    = (IDLE_CYC > 2) ? $clog2(IDLE_CYC) : 1;
    localparam int TAG_W     = ADDR_W - PAGE_BITS;

    rd_state_t         state_q, state_d;
    logic              accept;
    logic              wait_load;
    logic [WAIT_W-1:0] wait_len;
    logic              wait_done;
    logic              idle_run;
    logic              idle_expire;
    logic              page_hit;
    logic              tag_set;
    logic              tag_clr;
    logic              capture;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] rsp_data_q;
    logic              rsp_valid_q;

    assign accept   = req_valid && req_ready;
    assign capture  = ((state_q == ST_RAND) || (state_q == ST_PAGE)) && wait_done;
    assign idle_run = (state_q == ST_OPEN) && !accept;

    pflash_wait_timer #(.W(WAIT_W)) u_wait (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (wait_load),
        .load_cycles (wait_len),
        .done        (wait_done)
    );

    pflash_idle_timer #(.LIMIT(IDLE_CYC), .W(IDLE_W)) u_idle (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (idle_run),
        .expire (idle_expire)
    );

    pflash_page_tag #(.TAG_W(TAG_W)) u_tag (
        .clk       (clk),
        .rst_n     (rst_n),
        .set       (tag_set),
        .clear     (tag_clr),
        .set_tag   (addr_q[ADDR_W-1:PAGE_BITS]),
        .probe_tag (req_addr[ADDR_W-1:PAGE_BITS]),
        .hit       (page_hit)
    );

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_CLOSED;
        else        state_q <= state_d;
    end

    // Next state and timer/tag control.
    always_comb begin
        state_d   = state_q;
        wait_load = 1'b0;
        wait_len  = WAIT_W'(RAND_CYC);
        tag_set   = 1'b0;
        tag_clr   = 1'b0;
        unique case (state_q)
            ST_CLOSED: begin
                if (accept) begin
                    state_d   = ST_RAND;
                    wait_load = 1'b1;
                end
            end
            ST_RAND, ST_PAGE: begin
                if (wait_done) begin
                    state_d = ST_OPEN;
                    tag_set = 1'b1;
                end
            end
            ST_OPEN: begin
                if (accept) begin
                    wait_load = 1'b1;
                    if (page_hit) begin
                        state_d  = ST_PAGE;
                        wait_len = WAIT_W'(PAGE_CYC);
                    end else begin
                        state_d = ST_RAND;
                    end
                end else if (idle_expire) begin
                    state_d = ST_CLOSED;
                    tag_clr = 1'b1;
                end
            end
            default: state_d = ST_CLOSED;
        endcase
    end

    // Strobes and handshake follow the state.
    always_comb begin
        fl_ce_n   = (state_q == ST_CLOSED);
        fl_oe_n   = (state_q == ST_CLOSED);
        fl_we_n   = 1'b1;
        req_ready = (state_q == ST_CLOSED) || (state_q == ST_OPEN);
    end

    // Address latch and read data capture.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q      <= '0;
            rsp_data_q  <= '0;
            rsp_valid_q <= 1'b0;
        end else begin
            if (accept) addr_q <= req_addr;
            if (capture) rsp_data_q <= fl_dq;
            rsp_valid_q <= capture;
        end
    end

    assign fl_addr   = addr_q;
    assign rsp_data  = rsp_data_q;
    assign rsp_valid = rsp_valid_q;
endmodule

// File: rtl/pflash_rd_sva.sv
module pflash_rd_sva #(
    parameter int ADDR_W   = 23,
    parameter int WAIT_MAX = 6,
    parameter int IDLE_MAX = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              fl_ce_n,
    input logic              fl_oe_n,
    input logic              fl_we_n,
    input logic [ADDR_W-1:0] fl_addr
);
    int busy_run;
    int idle_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_run <= 0;
            idle_run <= 0;
        end else begin
            busy_run <= !req_ready ? busy_run + 1 : 0;
            idle_run <= (!fl_ce_n && req_ready && !req_valid) ? idle_run + 1 : 0;
        end
    end

    p_reset_closed_r1: assert property (@(posedge clk) !rst_n |=> (fl_ce_n && req_ready && !rsp_valid));
    p_busy_selects_r2: assert property (@(posedge clk) disable iff (!rst_n) !req_ready |-> !fl_ce_n);
    p_wait_bound_r3: assert property (@(posedge clk) disable iff (!rst_n) busy_run <= WAIT_MAX);
    p_ack_single_r6: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |=> !rsp_valid);
    p_ack_after_wait_r6: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |-> $past(!req_ready));
    p_write_off_r7: assert property (@(posedge clk) disable iff (!rst_n) fl_we_n);
    p_idle_close_r8: assert property (@(posedge clk) disable iff (!rst_n) (IDLE_MAX > 0 && idle_run >= IDLE_MAX) |-> fl_ce_n);
    p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n) (!req_ready && $past(!req_ready)) |-> $stable(fl_addr));
    p_oe_tracks_ce_r11: assert property (@(posedge clk) disable iff (!rst_n) fl_oe_n == fl_ce_n);
endmodule

bind pflash_rd_ctrl pflash_rd_sva #(
    .ADDR_W   (ADDR_W),
    .WAIT_MAX (RAND_CYC),
    .IDLE_MAX (IDLE_CYC)
) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .fl_ce_n   (fl_ce_n),
    .fl_oe_n   (fl_oe_n),
    .fl_we_n   (fl_we_n),
    .fl_addr   (fl_addr)
);

// File: tb/pflash_rd_ctrl_test.sv
module pflash_rd_ctrl_test;
    localparam int RAND = 6;
    localparam int PAGE = 2;
    localparam int IDLE = 16;
    localparam logic [15:0] POISON = 16'hDEAD;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [22:0] req_addr = '0;
    logic        req_ready, rsp_valid, fl_ce_n, fl_oe_n, fl_we_n;
    logic [15:0] rsp_data;
    logic [22:0] fl_addr;
    logic [15:0] fl_dq;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    pflash_rd_ctrl #(
        .CLK_NS(10), .T_ACC_NS(55), .T_PAGE_NS(20), .T_OE_NS(25), .IDLE_CYC(IDLE)
    ) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n),
        .fl_addr(fl_addr), .fl_dq(fl_dq)
    );

    function automatic logic [15:0] pat(input logic [22:0] a);
        return a[15:0] ^ {a[22:16], a[22:20], 6'h2B};
    endfunction

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Flash responder: poison word unless the access times are met.
    int r_age = 0, w_age = 0;
    logic [22:0] last_a = '0;
    always @(negedge clk) begin
        if (fl_ce_n) begin
            r_age = 0;
            w_age = 0;
        end else begin
            if (r_age == 0 || fl_addr[22:3] != last_a[22:3]) r_age = 1; else r_age++;
            if (w_age == 0 || fl_addr != last_a) w_age = 1; else w_age++;
        end
        last_a = fl_addr;
    end
    assign fl_dq = (!fl_ce_n && !fl_oe_n && r_age >= RAND && w_age >= PAGE) ? pat(fl_addr) : POISON;

    // Behavioural reference, advanced on every rising edge.
    int m_busy = 0, m_idle = 0;
    bit m_open = 0, m_rsp = 0;
    logic [22:0] m_addr = '0;
    logic [19:0] m_page = '0;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_idle = 0; m_open = 0; m_rsp = 0;
        end else begin
            m_rsp = 0;
            if (m_busy > 0) begin
                m_busy--;
                if (m_busy == 0) begin
                    m_rsp = 1; m_open = 1; m_idle = 0; m_page = m_addr[22:3];
                end
            end else if (req_valid) begin
                m_busy = (m_open && req_addr[22:3] == m_page) ? PAGE : RAND;
                m_addr = req_addr;
            end else if (m_open) begin
                m_idle++;
                if (m_idle == IDLE) m_open = 0;
            end
        end
    end

    // Compare on every cycle, away from the rising edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(fl_ce_n == !(m_open || m_busy > 0), "R8", "fl_ce_n", fl_ce_n, !(m_open || m_busy > 0));
            check(fl_oe_n == fl_ce_n, "R11", "fl_oe_n", fl_oe_n, fl_ce_n);
            check(fl_we_n == 1'b1, "R7", "fl_we_n", fl_we_n, 1);
            check(req_ready == (m_busy == 0), "R2", "req_ready", req_ready, m_busy == 0);
            check(rsp_valid == m_rsp, "R6", "rsp_valid", rsp_valid, m_rsp);
            if (m_rsp) check(rsp_data == pat(m_addr), "R6", "rsp_data", rsp_data, pat(m_addr));
            if (m_busy > 0) check(fl_addr == m_addr, "R10", "fl_addr", fl_addr, m_addr);
        end
    end

    task automatic do_read(input logic [22:0] a, input int gap, input int exp_lat, input string req);
        int lat;
        repeat (gap) @(negedge clk);
        req_addr = a;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_valid && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        if (exp_lat > 0) check(lat == exp_lat, req, "latency", lat, exp_lat);
        check(rsp_data == pat(a), "R6", "read word", rsp_data, pat(a));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        check(fl_ce_n && fl_oe_n && fl_we_n, "R1", "strobes in reset", {fl_ce_n, fl_oe_n, fl_we_n}, 3'b111);
        check(req_ready && !rsp_valid, "R1", "ready/valid in reset", {req_ready, rsp_valid}, 2'b10);
        rst_n = 1'b1;
        @(negedge clk);

        do_read(23'h000010, 0, RAND + 1, "R3");
        do_read(23'h000013, 0, PAGE + 1, "R4");
        do_read(23'h000017, 2, PAGE + 1, "R4");
        do_read(23'h000020, 0, RAND + 1, "R5");
        do_read(23'h000025, IDLE - 1, PAGE + 1, "R9");
        repeat (IDLE) @(negedge clk);
        check(fl_ce_n == 1'b1, "R8", "strobe released after idle", fl_ce_n, 1);
        do_read(23'h000026, 0, RAND + 1, "R8");
        do_read(23'h7FFFF8, 0, RAND + 1, "R3");
        do_read(23'h7FFFFF, 0, PAGE + 1, "R4");
        do_read(23'h3FFFFF, 0, RAND + 1, "R5");

        begin
            logic [15:0] lf = 16'hACE1;
            for (int i = 0; i < 80; i++) begin
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                do_read({lf[15:13], 15'h0, lf[4:3], lf[2:0]}, int'(lf[8:4]) % (IDLE + 3), 0, "R4");
            end
        end

        repeat (IDLE + 3) @(negedge clk);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule